// File: doc/BRIEF.md
# Block Median Sorter

This block computes the median of consecutive, non-overlapping blocks of samples. Each accepted sample goes straight into a bank of registers that is always kept in ascending order. Every register has its own magnitude comparator against the broadcast input, and each one decides locally whether to hold, take the value of its upper neighbour, or take the new sample. Because of this, an insert costs one clock whatever the block size, and the area grows linearly with the block length.

When the last sample of a block has been inserted, the middle register holds the median. It is presented for one cycle. During that same cycle the bank is treated as empty, so a sample arriving then becomes the first entry of the next block. Samples may come on every clock or with any number of idle cycles between them.

Top module: `blk_median_sort`

## Requirements
- R1: After reset, `median_valid_o` and `median_o` are both 0, and the first sample accepted starts a new block.
- R2: `median_valid_o` is high for exactly one cycle, on the clock edge that follows the BLK_N-th accepted sample of a block. It is low in every other cycle.
- R3: While `median_valid_o` is high, `median_o` equals the element at 0-based rank (BLK_N-1)/2 of that block's samples sorted in ascending unsigned order. With the defaults (BLK_N=101) this is rank 50, the register at index 50.
- R4: `median_o` is 0 whenever `median_valid_o` is low.
- R5: A cycle with `sample_valid_i` low does not change the block, whatever value is on `sample_i`. Idle cycles of any length between samples leave the median unchanged.
- R6: Each block starts from an all-zero bank. Values from an earlier block never influence a later median.
- R7: A sample accepted in the cycle in which `median_valid_o` is high counts as the first sample of the next block.
- R8: One sample is accepted per clock when `sample_valid_i` stays high on consecutive cycles.
- R9: Repeated values, including blocks made entirely of one value, give the correct median. A new value equal to a stored one is placed below it.
- R10: Samples of value 0, which equals the cleared contents, and of the all-ones maximum are handled like any other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_valid_i | input | 1 | The sample on `sample_i` is accepted this cycle |
| sample_i | input | DATA_W | Unsigned sample value |
| median_valid_o | output | 1 | One-cycle pulse marking the end of a block |
| median_o | output | DATA_W | Block median while valid, 0 otherwise |

## Verification
The bench uses a small configuration (7 samples of 4 bits) so that every sample value is reachable, and it computes each expected median by sorting the block itself.

- Ascending and descending blocks show whether a new value goes to the correct end of the bank.
- Alternating minimum and maximum values drive the shift chain from both sides.
- A sweep of every constant value tests ties and the zero value, which looks like an empty register.
- A maximum block followed by an all-zero block shows whether the bank is cleared between blocks.
- Back-to-back blocks exercise the sample that arrives in the pulse cycle.
- Random data with random idle gaps carrying junk on the data input checks that cycles without a valid sample are ignored.

// File: rtl/med_pkg.sv
package med_pkg;

  // action chosen by one sorted cell for the next clock
  typedef enum logic [1:0] {
    CELL_HOLD  = 2'd0,
    CELL_SHIFT = 2'd1,
    CELL_LOAD  = 2'd2,
    CELL_ZERO  = 2'd3
  } cell_op_e;

  function automatic int unsigned mid_rank(input int unsigned n);
    return (n - 1) / 2;
  endfunction

endpackage

// File: rtl/med_count.sv
module med_count #(
  parameter int unsigned BLK_N = 101,
  localparam int unsigned CNT_W = $clog2(BLK_N)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic clr_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(BLK_N - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             clr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clr_q <= 1'b0;
    end else begin
      clr_q <= valid_i && (cnt_q == LAST);
      if (valid_i) begin
        if (cnt_q == LAST) cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign clr_o = clr_q;

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  p_clr_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q |-> cnt_q <= CNT_W'(1));

  p_first_after_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_q && valid_i) |=> (cnt_q == CNT_W'(1)));

endmodule

// File: rtl/med_cell.sv
module med_cell
  import med_pkg::*;
#(
  parameter int unsigned DATA_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic [DATA_W-1:0] up_val_i,
  input  logic              up_gt_i,
  output logic [DATA_W-1:0] val_o,
  output logic [DATA_W-1:0] q_o,
  output logic              gt_o
);

  logic [DATA_W-1:0] q_r;
  logic [DATA_W-1:0] eff;
  cell_op_e          op;

  // contents as seen by this insert: a bank being cleared reads as empty
  assign eff  = clr_i ? '0 : q_r;
  assign gt_o = din_i > eff;  // ties give 0: the newcomer lands below

  always_comb begin
    if (valid_i && gt_o && up_gt_i) op = CELL_SHIFT;
    else if (valid_i && gt_o)       op = CELL_LOAD;
    else if (clr_i)                 op = CELL_ZERO;
    else                            op = CELL_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_r <= '0;
    else begin
      unique case (op)
        CELL_SHIFT: q_r <= up_val_i;
        CELL_LOAD:  q_r <= din_i;
        CELL_ZERO:  q_r <= '0;
        default:    q_r <= q_r;
      endcase
    end
  end

  assign val_o = eff;
  assign q_o   = q_r;

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !clr_i) |=> $stable(q_r));

  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !valid_i) |=> (q_r == '0));

endmodule

// File: rtl/blk_median_sort.sv
module blk_median_sort
  import med_pkg::*;
#(
  parameter int unsigned DATA_W = 14,
  parameter int unsigned BLK_N  = 101
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_valid_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              median_valid_o,
  output logic [DATA_W-1:0] median_o
);

  localparam int unsigned MID = mid_rank(BLK_N);

  logic              clr;
  logic [DATA_W-1:0] val [BLK_N+1];
  logic [DATA_W-1:0] q   [BLK_N];
  logic [BLK_N:0]    gt;

  // sentinel above the top cell: never greater, so the top can take the sample
  assign gt[BLK_N]  = 1'b0;
  assign val[BLK_N] = '0;

  med_count #(.BLK_N(BLK_N)) u_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (sample_valid_i),
    .clr_o   (clr)
  );

  for (genvar i = 0; i < BLK_N; i++) begin : g_cell
    med_cell #(.DATA_W(DATA_W)) u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .valid_i  (sample_valid_i),
      .clr_i    (clr),
      .din_i    (sample_i),
      .up_val_i (val[i+1]),
      .up_gt_i  (gt[i+1]),
      .val_o    (val[i]),
      .q_o      (q[i]),
      .gt_o     (gt[i])
    );
  end

  for (genvar i = 0; i + 1 < BLK_N; i++) begin : g_chk
    p_sorted_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      q[i] <= q[i+1]);
    p_gt_thermo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gt[i+1] |-> gt[i]);
  end

  assign median_valid_o = clr;
  assign median_o       = clr ? q[MID] : '0;

  p_pulse_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    median_valid_o |=> !median_valid_o);

  p_idle_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(median_valid_o) |-> (median_o == '0));

endmodule

// File: tb/sim_blk_median_sort.sv
module sim_blk_median_sort;

  localparam int CLK_PERIOD = 10;
  localparam int DW  = 4;
  localparam int BN  = 7;
  localparam int MID = (BN - 1) / 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sv = 1'b0;
  logic [DW-1:0] sd = '0;
  logic          mv;
  logic [DW-1:0] mo;

  int checks = 0;
  int errors = 0;
  int cnt = 0;
  bit done = 0;
  logic [DW-1:0] blk [BN];
  logic [15:0]   lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_median_sort #(.DATA_W(DW), .BLK_N(BN)) u0 (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .sample_valid_i (sv),
    .sample_i       (sd),
    .median_valid_o (mv),
    .median_o       (mo)
  );

  function automatic logic [DW-1:0] rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] med_of();
    logic [DW-1:0] s [BN];
    logic [DW-1:0] t;
    for (int i = 0; i < BN; i++) s[i] = blk[i];
    for (int i = 0; i < BN; i++)
      for (int j = 0; j + 1 < BN - i; j++)
        if (s[j] > s[j+1]) begin t = s[j]; s[j] = s[j+1]; s[j+1] = t; end
    return s[MID];
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle, then check the outputs one time unit after the edge
  task automatic cyc(bit v, logic [DW-1:0] x, string tag);
    bit            nxt_v;
    logic [DW-1:0] m;
    sv = v;
    sd = x;
    m  = '0;
    if (v) begin
      blk[cnt] = x;
      cnt++;
    end
    nxt_v = v && (cnt == BN);
    if (nxt_v) begin
      m   = med_of();
      cnt = 0;
    end
    @(posedge clk);
    #1;
    check({"R2 pulse ", tag}, int'(mv), int'(nxt_v));
    if (nxt_v) check({"R3 median ", tag}, int'(mo), int'(m));
    else       check({"R4 idle zero ", tag}, int'(mo), 0);
  endtask

  // mode: 0 ascending, 1 descending, 2 constant c, 3 alternating min/max, 4 random
  task automatic run_block(int mode, int gap, logic [DW-1:0] c, string tag);
    logic [DW-1:0] x;
    for (int k = 0; k < BN; k++) begin
      case (mode)
        0:       x = DW'(k * 2);
        1:       x = DW'((BN - k) * 2);
        2:       x = c;
        3:       x = (k % 2 == 0) ? '0 : '1;
        default: x = rnd();
      endcase
      cyc(1'b1, x, tag);
      for (int g = 0; g < gap; g++) cyc(1'b0, rnd(), {"R5 ", tag});
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid", int'(mv), 0);
    check("R1 reset median", int'(mo), 0);
    rst_ni = 1'b1;
    @(posedge clk);
    #1;
    check("R1 after release", int'(mv), 0);

    run_block(0, 0, '0, "R1 first block ascending");
    run_block(1, 1, '0, "R3 descending");
    run_block(3, 0, '0, "R3 alternating");
    for (int v = 0; v < (1 << DW); v++)
      run_block(2, 0, DW'(v), "R9 R10 constant");
    run_block(2, 0, '1, "R10 max block");
    run_block(2, 0, '0, "R6 zero after max");
    run_block(4, 3, '0, "R5 gaps with junk");

    // half a block, long idle with junk, then finish it
    for (int k = 0; k < BN / 2; k++) cyc(1'b1, rnd(), "R5 partial");
    for (int g = 0; g < 20; g++) cyc(1'b0, rnd(), "R5 long idle");
    for (int k = BN / 2; k < BN; k++) cyc(1'b1, rnd(), "R5 resume");

    // back to back: a sample lands in every pulse cycle
    for (int b = 0; b < 20; b++) run_block(4, 0, '0, "R7 R8 back to back");

    for (int b = 0; b < 200; b++) run_block(4, b % 3, '0, "R3 R6 random");

    cyc(1'b0, '0, "R2 tail");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R2 actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule